// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a tick timer for a small processor. It holds a 32-bit count and a control word. On every cycle in which the tick-enable input is high and the counter is running, the count goes up by one. After each increment, the low 28 bits of the new count are compared with a programmed period. When they are equal, the timer acts according to its mode. Restart mode clears the count. One-shot mode freezes it. Continuous and disabled modes let it keep running. If interrupts are enabled, a match also sets a sticky pending flag, which drives a level interrupt line.

Software reaches both registers through one write port and a separate read selector. A write in a cycle takes priority over that cycle's tick. Writing the control word can clear the pending flag but can never set it.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register reads 0, the control word reads 0 and `irq_o` is low.
- R2: While running, the count increases by exactly 1 on each cycle with `tick_en` high and no register write. With `tick_en` low the count holds.
- R3: A match needs only count bits [27:0] to equal the period field, control bits [27:0]. Count bits [31:28] play no part in the compare.
- R4: Restart mode (control bits [31:30] = 2'b01): on a match the count becomes 0 in the same update, and counting carries on from 0.
- R5: One-shot mode (2'b10): on a match the count keeps the matched value and ignores further ticks until a write to either register. After that write, counting resumes.
- R6: Continuous mode (2'b11): on a match the count keeps incrementing. The low field wraps from 0x0FFFFFFF through 0 and matches again at the period value.
- R7: Disabled mode (2'b00): a match does not alter counting. The pending flag still follows R8.
- R8: A match sets the pending flag (control bit 28) only while interrupt-enable (control bit 29) is 1. `irq_o` always equals the pending flag.
- R9: The pending flag stays set until a control-word write carries 0 in bit 28. A control-word write with 1 in bit 28 never sets it.
- R10: A register write in a cycle suppresses that cycle's increment and match. The written value reads back on the next cycle.
- R11: A match fires only when an increment lands on the period value. A count written to equal the period does not set the pending flag.
- R12: With `rd_sel` = 0, `rd_data` shows the count. With `rd_sel` = 1, it shows the control word laid out as {mode[1:0], ie, pending, period[27:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 control word |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The assertions rely on a write cycle never being treated as a tick. They also rely on the mode and interrupt-enable values only changing through the write port, so that a match in one cycle is judged against the control word held in that same cycle. The stimulus keeps randomly generated periods and written counts small, so that matches occur often within a short run. Write strobes are rare enough that long stretches of ticking occur between writes. Directed sequences place the count next to the field wrap, hold it frozen after a one-shot match, and write it straight onto the period value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_RESTART = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_CONT    = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
    import tick_timer_pkg::*;
#(
    parameter int PER_W = 28,
    localparam int CNT_W = PER_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_any,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic [PER_W-1:0] period,
    input  tmr_mode_e        mode,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc_d;
    logic             adv_d;
    logic             match_d;

    always_comb begin
        st_d      = st_q;
        cnt_inc_d = st_q.cnt + CNT_W'(1);
        adv_d     = tick_en && st_q.run && !wr_any;
        match_d   = adv_d && (cnt_inc_d[PER_W-1:0] == period);
        if (wr_any) begin
            st_d.run = 1'b1;
            if (wr_cnt) st_d.cnt = wdata;
        end else if (adv_d) begin
            st_d.cnt = cnt_inc_d;
            if (match_d) begin
                case (mode)
                    MODE_RESTART: st_d.cnt = '0;
                    MODE_ONESHOT: st_d.run = 1'b0;
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign match_o = match_d;

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode == MODE_RESTART) |=> (cnt_o == '0));
    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_any) |=> $stable(cnt_o));
    // R6
    cont_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode == MODE_CONT) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_o == $past(wdata)));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tick_timer_pkg::*;
#(
    parameter int PER_W = 28,
    localparam int REG_W = PER_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    input  logic             match,
    output tmr_mode_e        mode_o,
    output logic [PER_W-1:0] period_o,
    output logic             pend_o,
    output logic [REG_W-1:0] reg_o
);
    typedef struct packed {
        tmr_mode_e        mode;
        logic             ie;
        logic             pend;
        logic [PER_W-1:0] period;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.mode   = tmr_mode_e'(wdata[REG_W-1 -: 2]);
            st_d.ie     = wdata[PER_W+1];
            st_d.pend   = st_q.pend & wdata[PER_W];
            st_d.period = wdata[PER_W-1:0];
        end else if (match && st_q.ie) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign period_o = st_q.period;
    assign pend_o   = st_q.pend;
    assign reg_o    = st_q;

    // R8
    pend_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(match && st_q.ie));
    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !(wr_ctl && !wdata[PER_W])) |=> pend_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int PER_W = 28,
    localparam int REG_W = PER_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_o
);
    tmr_mode_e        mode;
    logic [PER_W-1:0] period;
    logic [REG_W-1:0] cnt;
    logic [REG_W-1:0] ctl_word;
    logic             match;
    logic             pend;

    tmr_count #(.PER_W(PER_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_any  (wr_en),
        .wr_cnt  (wr_en && !wr_sel),
        .wdata   (wr_data),
        .period  (period),
        .mode    (mode),
        .cnt_o   (cnt),
        .match_o (match)
    );

    tmr_ctrl #(.PER_W(PER_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_en && wr_sel),
        .wdata    (wr_data),
        .match    (match),
        .mode_o   (mode),
        .period_o (period),
        .pend_o   (pend),
        .reg_o    (ctl_word)
    );

    assign rd_data = rd_sel ? ctl_word : cnt;
    assign irq_o   = pend;

    // R10
    no_match_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !match);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt;
    logic [1:0]  m_mode;
    logic        m_ie, m_pend, m_run;
    logic [27:0] m_per;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [31:0] ctl_word(input logic [1:0] md, input logic ie,
                                             input logic pd, input logic [27:0] per);
        return {md, ie, pd, per};
    endfunction

    function automatic logic [31:0] model_read(input logic rs);
        return rs ? ctl_word(m_mode, m_ie, m_pend, m_per) : m_cnt;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_mode = '0; m_ie = 0; m_pend = 0; m_per = '0; m_run = 1;
    endtask

    task automatic model_step(input logic tk, input logic we, input logic ws,
                              input logic [31:0] wd);
        logic [31:0] n;
        if (we) begin
            m_run = 1;
            if (!ws) m_cnt = wd;
            else begin
                m_mode = wd[31:30]; m_ie = wd[29];
                m_pend = m_pend && wd[28]; m_per = wd[27:0];
            end
        end else if (tk && m_run) begin
            n = m_cnt + 1;
            if (n[27:0] == m_per) begin
                if (m_ie) m_pend = 1;
                if (m_mode == 2'b01) n = '0;
                else if (m_mode == 2'b10) m_run = 0;
            end
            m_cnt = n;
        end
    endtask

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual irq/data %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic tk, input logic we, input logic ws,
                        input logic [31:0] wd, input logic rs, input string tag);
        tick_en = tk; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
        @(posedge clk);
        model_step(tk, we, ws, wd);
        @(negedge clk);
        check(tag, {irq_o, rd_data}, {m_pend, model_read(rs)});
    endtask

    task automatic wr(input logic ws, input logic [31:0] wd, input string tag);
        step(1'b1, 1'b1, ws, wd, ws, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset values
        rd_sel = 0; #1; check("R1 count", {irq_o, rd_data}, 33'h0);
        rd_sel = 1; #1; check("R1 ctl", {irq_o, rd_data}, 33'h0);

        // R2: count per tick, hold without tick
        wr(1, ctl_word(2'b00, 0, 0, 28'd1000), "R2 setup");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2 tick");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R2 hold");

        // R3: upper bits ignored in compare
        wr(0, 32'hF000_0003, "R3 setup");
        wr(1, ctl_word(2'b11, 1, 0, 28'd5), "R3 setup");
        step(1, 0, 0, 0, 0, "R3 tick");
        step(1, 0, 0, 0, 0, "R3 match");
        check("R8 irq", {32'h0, irq_o}, 33'h1);

        // R9: write 1 no effect, write 0 clears
        wr(1, ctl_word(2'b00, 0, 1, 28'd5), "R9 write one");
        check("R9 sticky", {32'h0, irq_o}, 33'h1);
        wr(1, ctl_word(2'b00, 0, 0, 28'd5), "R9 clear");
        check("R9 cleared", {32'h0, irq_o}, 33'h0);
        wr(1, ctl_word(2'b00, 0, 1, 28'd5), "R9 no set");
        check("R9 no set", {32'h0, irq_o}, 33'h0);

        // R4: restart mode
        wr(0, 32'h0, "R4 setup");
        wr(1, ctl_word(2'b01, 1, 0, 28'd3), "R4 setup");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, "R4 restart");

        // R5: one-shot stop and hold
        wr(0, 32'h0, "R5 setup");
        wr(1, ctl_word(2'b10, 0, 0, 28'd4), "R5 setup");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0, "R5 oneshot");
        check("R5 held value", {1'b0, rd_data}, 33'd4);
        wr(0, 32'd10, "R5 resume");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R5 resumed");

        // R11: count written onto period does not match
        wr(1, ctl_word(2'b11, 1, 0, 28'd7), "R11 setup");
        wr(0, 32'd7, "R11 write");
        step(0, 0, 0, 0, 0, "R11 idle");
        step(1, 0, 0, 0, 0, "R11 tick");
        check("R11 no irq", {32'h0, irq_o}, 33'h0);

        // R6: continuous wrap of the field
        wr(1, ctl_word(2'b11, 1, 0, 28'd2), "R6 setup");
        wr(0, 32'h0FFF_FFFE, "R6 setup");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R6 wrap");
        check("R6 after wrap", {irq_o, rd_data}, {1'b1, 32'h1000_0004});

        // R7: disabled mode keeps counting, still flags
        wr(1, ctl_word(2'b00, 1, 0, 28'd2), "R7 setup");
        wr(0, 32'h0, "R7 setup");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R7 off");
        check("R7 count", {irq_o, rd_data}, {1'b1, 32'd4});

        // R10: write beats tick
        wr(0, 32'd1, "R10 write");
        check("R10 no inc", {1'b0, rd_data}, 33'd1);

        // R12: control layout readback
        wr(1, 32'hA000_0123, "R12 layout");
        rd_sel = 1; #1;
        check("R12 ctl", {1'b0, rd_data}, 33'h0A000_0123);

        // random stimulus
        for (int i = 0; i < 4000; i++) begin
            logic we, ws, tk, rs;
            logic [31:0] wd;
            we = ($urandom_range(0, 15) == 0);
            ws = $urandom_range(0, 1);
            tk = ($urandom_range(0, 3) != 0);
            rs = $urandom_range(0, 1);
            if (ws) wd = ctl_word(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                                  1'($urandom_range(0, 1)), 28'($urandom_range(0, 15)));
            else    wd = {4'($urandom_range(0, 15)), 28'($urandom_range(0, 12))};
            step(tk, we, ws, wd, rs, "random model");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule